// File: doc/BRIEF.md
# Privilege Mode and Address Window Guard

This unit tracks whether the processor is running trusted system code or untrusted application code, and enforces both privilege modes on every cycle. It holds one mode flag, a window origin register, a window size register and a timer reload register. Each cycle it looks at the operation class and the memory access that instruction decode presents, together with any trap event. It then decides whether the access may proceed and whether a protection violation has occurred.

In monitor mode every address passes and the privileged operations take effect. In user mode an access must fall inside the window, and privileged operations are suppressed. A violation raises a fault flag, and a fault or an external trap returns the unit to monitor mode on the next clock edge. The only way into user mode is an explicit enter-user operation issued from monitor mode.

Top module: `prot_guard`

## Requirements
- R1: The mode output `userMode` is 0 for monitor mode and 1 for user mode.
- R2: During and after reset the unit is in monitor mode, and the timer reload register is 0.
- R3: When `trapEvent` is high, the next cycle is in monitor mode. This holds even if an enter-user operation is presented in the same cycle.
- R4: In user mode, an access with `accValid` high is allowed only when `winBase <= accAddr < winBase + winSize`. A size of 0 allows no address.
- R5: In monitor mode, every valid access is allowed, whatever the window registers hold.
- R6: The `opClass` codes are 0 plain, 1 I/O, 2 load window base, 3 load window size, 4 load timer reload, 5 enter user, and 6 and 7 plain. Codes 2, 3 and 4 copy `wrData` into their register at the clock edge, but only in monitor mode. `timerReload` shows the reload register.
- R7: Any of codes 1 to 5 issued in user mode has no effect. It raises `protFault` in the same cycle, and the next cycle is in monitor mode. A fault never lasts two consecutive cycles.
- R8: A valid user-mode access outside the window drives `accessOk` low and `protFault` high in the same cycle.
- R9: The mode changes from monitor to user only after code 5 is issued in monitor mode with no trap in that cycle.
- R10: The window end is computed without wraparound. When base plus size exceeds the address space, the window extends to the top address.
- R11: `accessOk` is 0 whenever `accValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A memory access is presented this cycle |
| accAddr | input | 32 | Address of the access |
| opClass | input | 3 | Operation class of the current instruction |
| wrData | input | 32 | Value for the register load operations |
| trapEvent | input | 1 | Interrupt or fault from elsewhere |
| accessOk | output | 1 | The access may proceed |
| protFault | output | 1 | Protection violation this cycle |
| userMode | output | 1 | Current mode, 1 for user |
| timerReload | output | 32 | Timer reload value |

## Verification
A wrong mode flag shows at the ports at once. Out-of-window accesses pass in monitor mode, or legal ones fault in user mode, and either appears on `accessOk` in the same cycle as the access. A corrupt window register shows only when a user-mode access probes near an edge. For that reason the vectors probe both ends of the window, the capped top of the address space and a zero size. Suppressed privileged loads are checked by probing the unchanged window afterwards, and by reading `timerReload`.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN   = 3'd0,
    OP_IO      = 3'd1,
    OP_LDBASE  = 3'd2,
    OP_LDSIZE  = 3'd3,
    OP_LDTIMER = 3'd4,
    OP_ENTERUS = 3'd5
  } op_e;

  typedef struct packed {
    logic ldBase;
    logic ldSize;
    logic ldTimer;
  } strobe_t;
endpackage

// File: rtl/prot_guard_dp.sv
module prot_guard_dp
  import prot_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              inRange,
  output logic [ADDR_W-1:0] timerReload
);
  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] sizeReg;
  logic [ADDR_W-1:0] reloadReg;
  logic [SUM_W-1:0]  winEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg   <= '0;
      sizeReg   <= '0;
      reloadReg <= '0;
    end else begin
      if (strb.ldBase)  baseReg   <= wrData;
      if (strb.ldSize)  sizeReg   <= wrData;
      if (strb.ldTimer) reloadReg <= wrData;
    end
  end

  // The extra bit keeps the end exact, so an overflowing sum caps at the top address.
  always_comb begin
    winEnd  = {1'b0, baseReg} + {1'b0, sizeReg};
    inRange = (accAddr >= baseReg) && ({1'b0, accAddr} < winEnd);
  end

  assign timerReload = reloadReg;

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (sizeReg == '0) |-> !inRange);  // R4
  AST_TOP_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (winEnd[ADDR_W] && accAddr >= baseReg) |-> inRange);  // R10
  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldTimer |=> timerReload == $past(wrData));  // R6
endmodule

// File: rtl/prot_guard_ctrl.sv
module prot_guard_ctrl
  import prot_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accValid,
  input  logic [2:0] opClass,
  input  logic       trapEvent,
  input  logic       inRange,
  output strobe_t    strb,
  output logic       accessOk,
  output logic       protFault,
  output logic       userMode
);
  logic modeQ;
  logic privOp;
  logic privFault;
  logic rangeFault;
  logic enterUser;

  always_comb begin
    privOp = (opClass == OP_IO) || (opClass == OP_LDBASE) || (opClass == OP_LDSIZE) ||
             (opClass == OP_LDTIMER) || (opClass == OP_ENTERUS);
    privFault  = modeQ && privOp;
    rangeFault = modeQ && accValid && !inRange;
    protFault  = privFault || rangeFault;
    accessOk   = accValid && (!modeQ || inRange);
    enterUser  = !modeQ && (opClass == OP_ENTERUS);
    strb.ldBase  = !modeQ && (opClass == OP_LDBASE);
    strb.ldSize  = !modeQ && (opClass == OP_LDSIZE);
    strb.ldTimer = !modeQ && (opClass == OP_LDTIMER);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        modeQ <= 1'b0;
    else if (trapEvent || protFault)  modeQ <= 1'b0;
    else if (enterUser)               modeQ <= 1'b1;
  end

  assign userMode = modeQ;

  AST_TRAP_TO_MONITOR: assert property (@(posedge clk) disable iff (!rstN)
    trapEvent |=> !userMode);  // R3
  AST_FAULT_TO_MONITOR: assert property (@(posedge clk) disable iff (!rstN)
    protFault |=> !userMode);  // R7
  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    protFault |=> !protFault);  // R7
  AST_MONITOR_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (!userMode && accValid) |-> accessOk);  // R5
  AST_OUTSIDE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (userMode && accValid && !inRange) |-> (!accessOk && protFault));  // R8
  AST_ENTRY_PATH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userMode) |-> ($past(opClass) == OP_ENTERUS && !$past(trapEvent)));  // R9
  AST_USER_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    userMode |-> !(strb.ldBase || strb.ldSize || strb.ldTimer));  // R6
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !accessOk);  // R11
endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [2:0]        opClass,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              trapEvent,
  output logic              accessOk,
  output logic              protFault,
  output logic              userMode,
  output logic [ADDR_W-1:0] timerReload
);
  strobe_t strb;
  logic    inRange;

  prot_guard_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .opClass(opClass),
    .trapEvent(trapEvent), .inRange(inRange), .strb(strb),
    .accessOk(accessOk), .protFault(protFault), .userMode(userMode)
  );

  prot_guard_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .accAddr(accAddr),
    .inRange(inRange), .timerReload(timerReload)
  );
endmodule

// File: tb/prot_guard_tb_top.sv
`timescale 1ns/100ps
module prot_guard_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid;
  logic [31:0] accAddr;
  logic [2:0]  opClass;
  logic [31:0] wrData;
  logic        trapEvent;
  logic        accessOk;
  logic        protFault;
  logic        userMode;
  logic [31:0] timerReload;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  prot_guard dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .opClass(opClass), .wrData(wrData), .trapEvent(trapEvent),
    .accessOk(accessOk), .protFault(protFault), .userMode(userMode),
    .timerReload(timerReload)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic        av;
    logic [31:0] addr;
    logic        trap;
    logic        eOk;
    logic        eFault;
    logic        eUser;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 32'h0000_1000, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0}, // R6 load base
    '{3'd3, 32'h0000_0100, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0}, // R6 load size
    '{3'd4, 32'h0000_ABCD, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0}, // R6 load reload
    '{3'd0, 32'h0,         1'b1, 32'h0,          1'b0, 1'b1, 1'b0, 1'b0}, // R5 monitor open
    '{3'd5, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0}, // R9 enter user
    '{3'd0, 32'h0,         1'b1, 32'h0000_1000,  1'b0, 1'b1, 1'b0, 1'b1}, // R4 low edge
    '{3'd0, 32'h0,         1'b1, 32'h0000_10FF,  1'b0, 1'b1, 1'b0, 1'b1}, // R4 high edge
    '{3'd0, 32'h0,         1'b1, 32'h0000_1100,  1'b0, 1'b0, 1'b1, 1'b1}, // R8 just past
    '{3'd0, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0}, // R7 back to monitor
    '{3'd5, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd0, 32'h0,         1'b1, 32'h0000_0FFF,  1'b0, 1'b0, 1'b1, 1'b1}, // R8 below base
    '{3'd5, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd2, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b1, 1'b1}, // R7 user load base
    '{3'd5, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd0, 32'h0,         1'b1, 32'h0000_1000,  1'b0, 1'b1, 1'b0, 1'b1}, // R7 base unchanged
    '{3'd1, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b1, 1'b1}, // R7 user I/O
    '{3'd5, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd0, 32'h0,         1'b1, 32'h0000_1000,  1'b1, 1'b1, 1'b0, 1'b1}, // R3 trap
    '{3'd0, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0}, // R3 monitor after trap
    '{3'd5, 32'h0,         1'b0, 32'h0,          1'b1, 1'b0, 1'b0, 1'b0}, // R3 trap beats entry
    '{3'd0, 32'h0,         1'b1, 32'h0000_0000,  1'b0, 1'b1, 1'b0, 1'b0}, // R3 R11 still monitor
    '{3'd2, 32'hFFFF_FF00, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd3, 32'h0000_0200, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd5, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd0, 32'h0,         1'b1, 32'hFFFF_FFFF,  1'b0, 1'b1, 1'b0, 1'b1}, // R10 capped top
    '{3'd0, 32'h0,         1'b1, 32'hFFFF_FEFF,  1'b0, 1'b0, 1'b1, 1'b1}, // R10 below base
    '{3'd3, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd5, 32'h0,         1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd0, 32'h0,         1'b1, 32'hFFFF_FF00,  1'b0, 1'b0, 1'b1, 1'b1}  // R4 empty window
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] d, input logic av,
                       input logic [31:0] a, input logic tr);
    @(negedge clk);
    opClass = op; wrData = d; accValid = av; accAddr = a; trapEvent = tr;
    #1;
  endtask

  initial begin
    rstN = 1'b0; accValid = 1'b0; accAddr = '0; opClass = 3'd0; wrData = '0; trapEvent = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset mode", {31'b0, userMode}, 32'd0);
    check("R2 reset reload", timerReload, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].data, VEC[i].av, VEC[i].addr, VEC[i].trap);
      check($sformatf("R1 R4 R8 vector %0d", i),
            {29'b0, accessOk, protFault, userMode},
            {29'b0, VEC[i].eOk, VEC[i].eFault, VEC[i].eUser});
    end

    // R6: reload written in monitor is visible; a user-mode reload write is suppressed (R7)
    drive(3'd0, 32'h0, 1'b0, 32'h0, 1'b0);
    check("R6 reload value", timerReload, 32'h0000_ABCD);
    drive(3'd5, 32'h0, 1'b0, 32'h0, 1'b0);
    drive(3'd4, 32'h1234_5678, 1'b0, 32'h0, 1'b0);
    check("R7 user reload fault", {31'b0, protFault}, 32'd1);
    drive(3'd0, 32'h0, 1'b0, 32'h0, 1'b0);
    check("R7 reload unchanged", timerReload, 32'h0000_ABCD);
    check("R7 monitor after fault", {31'b0, userMode}, 32'd0);
    check("R11 idle no grant", {31'b0, accessOk}, 32'd0);

    // R2: reset from user mode returns to monitor and clears reload
    drive(3'd5, 32'h0, 1'b0, 32'h0, 1'b0);
    drive(3'd0, 32'h0, 1'b0, 32'h0, 1'b0);
    check("R9 entered user", {31'b0, userMode}, 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    check("R2 reset from user", {31'b0, userMode}, 32'd0);
    check("R2 reload cleared", timerReload, 32'd0);
    rstN = 1'b1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule